// File: doc/BRIEF.md
# Subframe Sync Mark Detector

This block sits behind a line decoder and clock recovery stage. It takes one recovered data bit at a time and looks for the four fixed 12-bit marks that open the four subframes of a frame. Until it has confirmed the full cycle of marks at the right spacing, it writes nothing out. Once confirmed, it locks on the next first-subframe mark. It then delivers every 12-bit word, starting with that mark, to a receive FIFO.

The subframe length is the programmed number of words per subframe times 12 bits. Bits are taken least significant bit first: the first bit of a word received becomes bit 0. The mark values are octal 1107, 2670, 5107 and 6670 (hex 247, 5B8, A47, DB8) for subframes one to four. `words_per_sf` must be at least 1, and it may only be changed while `rst_n` is held low.

Both data sides use valid/ready. A bit is taken on a clock edge where `in_valid` and `in_ready` are both high. An output word is handed over on an edge where `out_valid` and `out_ready` are both high. While a word waits for `out_ready`, `in_ready` is low, so the line side is held back and no word is dropped or overwritten. `in_ready` does not depend on `in_valid`.

Top module: `sfs_detector`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `in_sync` and `out_valid` are 0 and `in_ready` is 1. This also holds when reset is applied in the middle of a locked stream.
- R2: In the hunt state the last 12 accepted bits are compared with the first mark (hex 247, LSB first) on every bit. The mark is therefore found at any bit offset in the stream.
- R3: After the first mark, the marks for subframes 2, 3 and 4 (hex 5B8, A47, DB8) must each end exactly `words_per_sf`×12 accepted bits after the previous mark. A mark out of order or at the wrong spacing prevents lock.
- R4: `in_sync` rises on the edge that accepts the last bit of the first-subframe mark that ends one subframe after a confirmed fourth mark. That mark (hex 247) is the first word delivered.
- R5: While locked, every 12-bit word is delivered in arrival order, assembled with the first received bit as bit 0. This includes the mark at the start of every subframe.
- R6: While locked, if the expected mark is missing at its subframe boundary, `in_sync` falls on that edge. That word is not delivered, and no further word is delivered until a new lock.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` stays stable, `out_valid` stays high and `in_ready` is low. No word is lost under back-pressure.
- R8: Mark spacing follows `words_per_sf`. A stream built with 2 words per subframe locks when `words_per_sf` is 2.
- R9: `out_valid` is never high while `in_sync` is low. No word is delivered before lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| words_per_sf | input | CNT_W | Words per subframe (at least 1) |
| in_valid | input | 1 | Recovered bit present |
| in_ready | output | 1 | Block can take a bit |
| in_data | input | 1 | Recovered bit value |
| out_valid | output | 1 | Word ready for the FIFO |
| out_ready | input | 1 | FIFO accepts the word |
| out_data | output | 12 | Word-aligned data, first received bit in bit 0 |
| in_sync | output | 1 | Frame lock achieved |

## Verification
Two events can fall on the same cycle. One is the subframe-boundary mark check, which may lock or drop sync. The other is a pending output word that the FIFO has not yet taken. The bench provokes this by pulsing `out_ready` low in a repeating pattern while marks complete. The block must then delay the mark check, by holding `in_ready` low, until the earlier word drains. The outcome is judged by comparing the full delivered word sequence against the sent one. The bench also counts every cycle in which a pending word coexists with `in_ready` high.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int WORD_W  = 12;
  localparam int N_MARKS = 4;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } sync_st_t;

  // Mark pattern for subframe k (k = 0 is the first subframe).
  function automatic logic [WORD_W-1:0] mark_of(input int k);
    case (k)
      0:       mark_of = 12'o1107;
      1:       mark_of = 12'o2670;
      2:       mark_of = 12'o5107;
      default: mark_of = 12'o6670;
    endcase
  endfunction
endpackage

// File: rtl/sfs_shift.sv
module sfs_shift
  import sfs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                bit_in,
  output logic [WORD_W-1:0]   sr_next,
  output logic [N_MARKS-1:0]  hit
);
  logic [WORD_W-1:0] sr_q;

  // LSB-first: the newest bit enters at the top and moves down.
  assign sr_next = {bit_in, sr_q[WORD_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n)    sr_q <= '0;
    else if (step) sr_q <= sr_next;
  end

  for (genvar k = 0; k < N_MARKS; k++) begin : g_cmp
    assign hit[k] = (sr_next == mark_of(k));
  end
endmodule

// File: rtl/sfs_timer.sv
module sfs_timer
  import sfs_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             restart,
  input  logic [CNT_W-1:0] words_per_sf,
  output logic             at_word_end,
  output logic             at_mark_slot
);
  localparam int BW_W = $clog2(WORD_W);
  localparam logic [BW_W-1:0] LAST_BIT = BW_W'(WORD_W - 1);

  logic [BW_W-1:0]  bit_q;
  logic [CNT_W-1:0] word_q;

  assign at_word_end  = (bit_q == LAST_BIT);
  assign at_mark_slot = at_word_end && (word_q == words_per_sf - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q  <= '0;
      word_q <= '0;
    end else if (step) begin
      if (restart) begin
        bit_q  <= '0;
        word_q <= '0;
      end else if (at_word_end) begin
        bit_q  <= '0;
        word_q <= at_mark_slot ? '0 : word_q + 1'b1;
      end else begin
        bit_q  <= bit_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfs_fsm.sv
module sfs_fsm
  import sfs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic [N_MARKS-1:0] hit,
  input  logic               at_word_end,
  input  logic               at_mark_slot,
  output logic               restart,
  output logic               emit,
  output logic               in_sync
);
  localparam int IDX_W = $clog2(N_MARKS);

  sync_st_t         st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             want_hit;

  assign want_hit = hit[idx_q];
  assign in_sync  = (st_q == ST_LOCKED);

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    restart = 1'b0;
    emit    = 1'b0;
    if (step) begin
      unique case (st_q)
        ST_HUNT: begin
          if (hit[0]) begin
            st_d    = ST_VERIFY;
            idx_d   = IDX_W'(1);
            restart = 1'b1;
          end
        end
        ST_VERIFY: begin
          if (at_mark_slot) begin
            if (want_hit) begin
              idx_d = idx_q + 1'b1;
              if (idx_q == '0) begin
                st_d = ST_LOCKED;
                emit = 1'b1;
              end
            end else if (hit[0]) begin
              idx_d   = IDX_W'(1);
              restart = 1'b1;
            end else begin
              st_d = ST_HUNT;
            end
          end
        end
        ST_LOCKED: begin
          if (at_mark_slot) begin
            if (want_hit) begin
              emit  = 1'b1;
              idx_d = idx_q + 1'b1;
            end else if (hit[0]) begin
              st_d    = ST_VERIFY;
              idx_d   = IDX_W'(1);
              restart = 1'b1;
            end else begin
              st_d = ST_HUNT;
            end
          end else if (at_word_end) begin
            emit = 1'b1;
          end
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_HUNT;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/sfs_detector.sv
module sfs_detector
  import sfs_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  words_per_sf,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              in_sync
);
  logic               step;
  logic [WORD_W-1:0]  sr_next;
  logic [N_MARKS-1:0] hit;
  logic               at_word_end, at_mark_slot;
  logic               restart, emit;

  assign in_ready = !out_valid || out_ready;
  assign step     = in_valid && in_ready;

  sfs_shift u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .bit_in  (in_data),
    .sr_next (sr_next),
    .hit     (hit)
  );

  sfs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .step         (step),
    .restart      (restart),
    .words_per_sf (words_per_sf),
    .at_word_end  (at_word_end),
    .at_mark_slot (at_mark_slot)
  );

  sfs_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .step         (step),
    .hit          (hit),
    .at_word_end  (at_word_end),
    .at_mark_slot (at_mark_slot),
    .restart      (restart),
    .emit         (emit),
    .in_sync      (in_sync)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_data  <= sr_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sfs_chk.sv
module sfs_chk
  import sfs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              in_sync
);
  // R7
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7
  stall_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R4
  lock_on_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> (out_valid && out_data == mark_of(0)));

  // R9
  no_word_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_sync);

  // R6
  drop_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sync) |-> !out_valid);
endmodule

bind sfs_detector sfs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .in_sync   (in_sync)
);

// File: tb/sfs_detector_tb_top.sv
module sfs_detector_tb_top;
  localparam int CNT_W = 14;
  localparam time T = 5ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] words_per_sf = 14'd4;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic             in_data = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [11:0]      out_data;
  logic             in_sync;

  int nchk = 0, nfail = 0;
  logic [11:0] cap [0:255];
  logic [11:0] expw [0:255];
  int ncap = 0, nexp = 0, nstall_bad = 0;
  bit bp_mode = 1'b0;
  int bp_cnt = 0;
  int nwords = 4;

  always #(T/2) clk = ~clk;

  sfs_detector #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .words_per_sf(words_per_sf),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .in_sync(in_sync)
  );

  // Ready pattern changes just after the rising edge.
  always @(posedge clk) begin
    #1;
    out_ready = bp_mode ? ((bp_cnt % 3) != 0) : 1'b1;
    bp_cnt++;
  end

  // Output monitor at the falling edge.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && ncap < 256) begin
      cap[ncap] = out_data;
      ncap++;
    end
    if (rst_n && out_valid && !out_ready && in_ready) nstall_bad++;
  end

  function automatic logic [11:0] mark(input int k);
    case (k)
      0: mark = 12'h247;
      1: mark = 12'h5B8;
      2: mark = 12'hA47;
      default: mark = 12'hDB8;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send_bit(input logic b);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_word(input logic [11:0] w, input bit exp_out);
    for (int i = 0; i < 12; i++) send_bit(w[i]);
    if (exp_out && nexp < 256) begin
      expw[nexp] = w;
      nexp++;
    end
  endtask

  task automatic send_subframe(input int k, input bit exp_out);
    send_word(mark(k), exp_out);
    for (int j = 1; j < nwords; j++)
      send_word(exp_out ? 12'(16 * k + j + 12'h301) : 12'h000, exp_out);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input int words);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    words_per_sf = CNT_W'(words);
    nwords = words;
    repeat (3) @(negedge clk);
    ncap = 0; nexp = 0; nstall_bad = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cmp_stream(input string req);
    chk(ncap == nexp, req, ncap, nexp);
    for (int i = 0; i < ncap && i < nexp; i++)
      chk(cap[i] == expw[i], req, int'(cap[i]), int'(expw[i]));
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!in_sync && !out_valid && in_ready, "R1 reset state",
        {in_sync, out_valid, in_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!in_sync && !out_valid && in_ready, "R1 after reset",
        {in_sync, out_valid, in_ready}, 3'b001);
  endtask

  task automatic t_lock_basic;
    do_reset(4);
    for (int i = 0; i < 5; i++) send_bit(1'b0);  // R2: off-word prefix
    for (int k = 0; k < 4; k++) send_subframe(k, 1'b0);
    chk(!in_sync, "R9 not locked after one frame", in_sync, 0);
    chk(ncap == 0, "R9 no words before lock", ncap, 0);
    send_word(mark(0), 1'b1);
    chk(in_sync, "R4 lock on next first mark", in_sync, 1);
    for (int j = 1; j < nwords; j++) send_word(12'(j + 12'h0A0), 1'b1);
    for (int k = 1; k < 4; k++) send_subframe(k, 1'b1);
    send_subframe(0, 1'b1);
    idle(4);
    chk(ncap > 0 && cap[0] == 12'h247, "R4 first word is mark", int'(cap[0]), 12'h247);
    cmp_stream("R5 word stream");
    chk(in_sync, "R5 stays locked", in_sync, 1);
  endtask

  task automatic t_out_of_order;
    do_reset(4);
    send_subframe(0, 1'b0);
    send_subframe(2, 1'b0);
    send_subframe(1, 1'b0);
    send_subframe(3, 1'b0);
    send_subframe(0, 1'b0);
    idle(4);
    chk(!in_sync, "R3 order violation blocks lock", in_sync, 0);
    chk(ncap == 0, "R3 no words on order violation", ncap, 0);
  endtask

  task automatic t_bad_spacing;
    do_reset(4);
    send_subframe(0, 1'b0);
    send_word(12'h000, 1'b0);  // one extra word
    for (int k = 1; k < 4; k++) send_subframe(k, 1'b0);
    send_subframe(0, 1'b0);
    idle(4);
    chk(!in_sync, "R3 spacing violation blocks lock", in_sync, 0);
    chk(ncap == 0, "R3 no words on spacing violation", ncap, 0);
  endtask

  task automatic t_loss;
    do_reset(4);
    for (int k = 0; k < 4; k++) send_subframe(k, 1'b0);
    send_subframe(0, 1'b1);
    send_subframe(1, 1'b1);
    send_word(12'h000, 1'b0);  // third mark missing
    chk(!in_sync, "R6 sync drops on missing mark", in_sync, 0);
    for (int j = 1; j < nwords; j++) send_word(12'h000, 1'b0);
    send_subframe(3, 1'b0);
    send_subframe(0, 1'b0);
    idle(4);
    chk(!in_sync, "R6 no relock without full sequence", in_sync, 0);
    cmp_stream("R6 words until loss only");
  endtask

  task automatic t_backpressure;
    do_reset(4);
    bp_mode = 1'b1;
    for (int k = 0; k < 4; k++) send_subframe(k, 1'b0);
    for (int k = 0; k < 4; k++) send_subframe(k, 1'b1);
    send_subframe(0, 1'b1);
    idle(12);
    bp_mode = 1'b0;
    idle(2);
    chk(nstall_bad == 0, "R7 input stalled while word pending", nstall_bad, 0);
    cmp_stream("R7 no word lost under back-pressure");
  endtask

  task automatic t_rate;
    do_reset(2);
    for (int k = 0; k < 4; k++) send_subframe(k, 1'b0);
    send_subframe(0, 1'b1);
    chk(in_sync, "R8 lock at two words per subframe", in_sync, 1);
    for (int k = 1; k < 4; k++) send_subframe(k, 1'b1);
    idle(4);
    cmp_stream("R8 stream at two words per subframe");
  endtask

  task automatic t_reset_mid;
    do_reset(4);
    for (int k = 0; k < 4; k++) send_subframe(k, 1'b0);
    send_subframe(0, 1'b1);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(!in_sync && !out_valid, "R1 reset clears lock", {in_sync, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!in_sync && in_ready, "R1 cleared after mid-stream reset",
        {in_sync, in_ready}, 2'b01);
  endtask

  initial begin
    #(T * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_lock_basic();
    t_out_of_order();
    t_bad_spacing();
    t_loss();
    t_backpressure();
    t_rate();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule